// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Local Operation Decoder

This block is the execution core of a simple processor datapath: a purely combinational arithmetic-logic unit paired with the small decoder that chooses its operation. The main controller supplies a 2-bit operation class and the instruction supplies a 6-bit function field. The decoder either forces an addition or a subtraction for address, increment and compare work, or lets the function field pick among bitwise AND, bitwise OR, add, subtract and signed set-on-less-than.

The unit returns the result word, a flag that is high when every result bit is clear, and a signed overflow flag for the two arithmetic operations. The chosen 3-bit select is also brought out so that the surrounding control logic and any observer can see which operation was applied. There is no clock and no state: every output follows the inputs within the same cycle.

Top module: `alu_unit`

## Requirements
- R1: With `alu_op_i` = 00 the select is add (`op_sel_o` = 010) whatever the function field holds.
- R2: With `alu_op_i` = 01 the select is subtract (`op_sel_o` = 110) whatever the function field holds.
- R3: With `alu_op_i[1]` = 1 the function field chooses the select: 100000 gives add (010), 100010 subtract (110), 100100 AND (000), 100101 OR (001), 101010 set-on-less-than (111).
- R4: With `alu_op_i[1]` = 1 any other function code gives the add select (010).
- R5: Select 000 returns the bitwise AND of the operands and select 001 their bitwise OR.
- R6: Select 010 returns the operand sum and select 110 returns `a_i` minus `b_i`, both modulo 2^32.
- R7: Select 111 returns 1 in bit 0 when `a_i` is less than `b_i` as two's-complement values, else 0; bits 31 to 1 are always 0.
- R8: `zero_o` is 1 exactly when all 32 result bits are 0.
- R9: For add and subtract, `overflow_o` is 1 exactly when the true signed result lies outside the 32-bit two's-complement range.
- R10: For AND, OR and set-on-less-than, `overflow_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op_i | input | 2 | Operation class from the main controller |
| funct_i | input | 6 | Function field of the instruction |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |
| op_sel_o | output | 3 | Operation select applied to the datapath |

## Verification
Every result, flag and the select are due in the same cycle the inputs change, with no register in between. The bench drives a new vector on the falling clock edge and samples all four outputs two nanoseconds later, well before the next rising edge, so each check sees settled values from that one vector. Random vectors mix all operation classes, legal and illegal function codes and extreme operand values, while directed cases cover the overflow boundaries, equal operands and signed comparisons across the sign boundary.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    SEL_AND = 3'b000,
    SEL_OR  = 3'b001,
    SEL_ADD = 3'b010,
    SEL_SUB = 3'b110,
    SEL_SLT = 3'b111
  } alu_sel_e;

  localparam logic [1:0] CLS_ADD = 2'b00;
  localparam logic [1:0] CLS_SUB = 2'b01;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_pkg::*;
#(
  parameter int CLS_W = 2,
  parameter int FN_W  = 6
) (
  input  logic [CLS_W-1:0] alu_op_i,
  input  logic [FN_W-1:0]  funct_i,
  output alu_sel_e         sel_o
);

  alu_sel_e fn_sel;

  always_comb begin
    unique case (funct_i)
      FN_SUB:  fn_sel = SEL_SUB;
      FN_AND:  fn_sel = SEL_AND;
      FN_OR:   fn_sel = SEL_OR;
      FN_SLT:  fn_sel = SEL_SLT;
      default: fn_sel = SEL_ADD;  // covers FN_ADD and undefined codes
    endcase
  end

  always_comb begin
    if (alu_op_i[CLS_W-1])        sel_o = fn_sel;
    else if (alu_op_i == CLS_SUB) sel_o = SEL_SUB;
    else                          sel_o = SEL_ADD;
  end

  always_comb begin
    AST_FORCED_ADD: assert (alu_op_i != CLS_ADD || sel_o == SEL_ADD)
      else $error("forced add class gave select %b", sel_o);  // R1
    AST_FORCED_SUB: assert (alu_op_i != CLS_SUB || sel_o == SEL_SUB)
      else $error("forced subtract class gave select %b", sel_o);  // R2
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         less_o
);

  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    sum_o  = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
    // same-sign inputs producing an opposite-sign sum
    ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    // true sign of a-b, corrected for wrap
    less_o = sum_o[MSB] ^ ovf_o;
  end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         use_or_i,
  output logic [W-1:0] y_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_o[i] = use_or_i ? (a_i[i] | b_i[i]) : (a_i[i] & b_i[i]);
  end

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CLS_W = 2,
  parameter int FN_W  = 6
) (
  input  logic [CLS_W-1:0] alu_op_i,
  input  logic [FN_W-1:0]  funct_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o,
  output logic [2:0]       op_sel_o
);

  localparam int MSB = WIDTH - 1;

  alu_sel_e         sel;
  logic [WIDTH-1:0] arith_y;
  logic [WIDTH-1:0] logic_y;
  logic             arith_ovf;
  logic             arith_less;
  logic             is_arith;

  alu_op_decoder #(.CLS_W(CLS_W), .FN_W(FN_W)) u_dec (
    .alu_op_i (alu_op_i),
    .funct_i  (funct_i),
    .sel_o    (sel)
  );

  // select bit 2 means "negate b", shared by subtract and compare
  alu_addsub #(.W(WIDTH)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sel[2]),
    .sum_o  (arith_y),
    .ovf_o  (arith_ovf),
    .less_o (arith_less)
  );

  alu_bitwise #(.W(WIDTH)) u_bitwise (
    .a_i      (a_i),
    .b_i      (b_i),
    .use_or_i (sel[0]),
    .y_o      (logic_y)
  );

  always_comb begin
    is_arith = (sel == SEL_ADD) || (sel == SEL_SUB);
    unique case (sel)
      SEL_AND, SEL_OR:  result_o = logic_y;
      SEL_SLT:          result_o = {{(WIDTH-1){1'b0}}, arith_less};
      default:          result_o = arith_y;
    endcase
    overflow_o = arith_ovf & is_arith;
    zero_o     = ~|result_o;
    op_sel_o   = sel;
  end

  always_comb begin
    AST_LEGAL_SEL: assert (sel inside {SEL_AND, SEL_OR, SEL_ADD, SEL_SUB, SEL_SLT})
      else $error("illegal select %b", sel);  // R3
    AST_NO_OVERFLOW: assert (!overflow_o || is_arith)
      else $error("overflow on non-arithmetic select %b", sel);  // R10
    AST_ADD_OVF_SIGNS: assert (!(sel == SEL_ADD && overflow_o) || (a_i[MSB] == b_i[MSB]))
      else $error("add overflow with differing operand signs");  // R9
    AST_SUB_EQUAL_ZERO: assert (!(sel == SEL_SUB && a_i == b_i) || (zero_o && !overflow_o))
      else $error("equal operands did not subtract to zero");  // R8
    AST_SLT_EQUAL: assert (!(sel == SEL_SLT && a_i == b_i) || zero_o)
      else $error("compare of equal operands not zero");  // R7
  end

endmodule

// File: tb/alu_unit_test.sv
module alu_unit_test;

  logic        clk = 1'b0;
  logic [1:0]  alu_op;
  logic [5:0]  funct;
  logic [31:0] a, b;
  logic [31:0] result;
  logic        zero, ovf;
  logic [2:0]  op_sel;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_unit uut (
    .alu_op_i   (alu_op),
    .funct_i    (funct),
    .a_i        (a),
    .b_i        (b),
    .result_o   (result),
    .zero_o     (zero),
    .overflow_o (ovf),
    .op_sel_o   (op_sel)
  );

  function automatic logic [2:0] exp_sel(input logic [1:0] op, input logic [5:0] fn);
    if (op == 2'b00) return 3'b010;
    if (op == 2'b01) return 3'b110;
    case (fn)
      6'b100000: return 3'b010;
      6'b100010: return 3'b110;
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      6'b101010: return 3'b111;
      default:   return 3'b010;
    endcase
  endfunction

  function automatic logic [31:0] exp_res(input logic [2:0] s, input logic [31:0] x, input logic [31:0] y);
    case (s)
      3'b000:  return x & y;
      3'b001:  return x | y;
      3'b110:  return x - y;
      3'b111:  return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return x + y;
    endcase
  endfunction

  function automatic logic exp_ovf(input logic [2:0] s, input logic [31:0] x, input logic [31:0] y);
    longint t;
    if (s == 3'b010)      t = longint'($signed(x)) + longint'($signed(y));
    else if (s == 3'b110) t = longint'($signed(x)) - longint'($signed(y));
    else return 1'b0;
    return (t > 64'sd2147483647) || (t < -64'sd2147483648);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [5:0] fn,
                       input logic [31:0] x, input logic [31:0] y);
    logic [2:0]  es;
    logic [31:0] er;
    string sel_tag, res_tag, ovf_tag;
    @(negedge clk);
    alu_op = op; funct = fn; a = x; b = y;
    #2;
    es = exp_sel(op, fn);
    er = exp_res(es, x, y);
    if (op == 2'b00)      sel_tag = "R1 select";
    else if (op == 2'b01) sel_tag = "R2 select";
    else if (fn inside {6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010})
                          sel_tag = "R3 select";
    else                  sel_tag = "R4 select";
    case (es)
      3'b000, 3'b001: res_tag = "R5 result";
      3'b111:         res_tag = "R7 result";
      default:        res_tag = "R6 result";
    endcase
    ovf_tag = (es == 3'b010 || es == 3'b110) ? "R9 overflow" : "R10 overflow";
    check(sel_tag, {29'd0, op_sel}, {29'd0, es});
    check(res_tag, result, er);
    check("R8 zero", {31'd0, zero}, {31'd0, (er == 32'd0)});
    check(ovf_tag, {31'd0, ovf}, {31'd0, exp_ovf(es, x, y)});
  endtask

  function automatic logic [31:0] pick_operand();
    case ($urandom_range(0, 7))
      0: return 32'h7fffffff;
      1: return 32'h80000000;
      2: return 32'hffffffff;
      3: return 32'h00000000;
      4: return 32'h00000001;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [5:0] pick_funct();
    case ($urandom_range(0, 6))
      0: return 6'b100000;
      1: return 6'b100010;
      2: return 6'b100100;
      3: return 6'b100101;
      4: return 6'b101010;
      default: return 6'($urandom);
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20141);
    alu_op = 2'b00; funct = 6'd0; a = 32'd0; b = 32'd0;
    #2;
    // reset-like idle state: add of zeros
    check("R8 idle zero", {31'd0, zero}, 32'd1);
    check("R1 idle select", {29'd0, op_sel}, 32'd2);

    // directed corners
    apply(2'b00, 6'b100100, 32'h7fffffff, 32'h00000001);  // R1 forced add, R9 overflow
    apply(2'b01, 6'b100000, 32'h80000000, 32'h00000001);  // R2 forced sub, R9 overflow
    apply(2'b01, 6'b101010, 32'h12345678, 32'h12345678);  // R8 zero on equal
    apply(2'b10, 6'b100000, 32'hffffffff, 32'h00000001);  // R6 wrap, no overflow
    apply(2'b10, 6'b100010, 32'h00000000, 32'h80000000);  // R9 sub overflow
    apply(2'b10, 6'b100100, 32'hf0f0f0f0, 32'h0ff00ff0);  // R5 and
    apply(2'b10, 6'b100101, 32'hf0f0f0f0, 32'h0ff00ff0);  // R5 or
    apply(2'b10, 6'b100100, 32'haaaaaaaa, 32'h55555555);  // R8 zero from and, R10
    apply(2'b10, 6'b101010, 32'h80000000, 32'h7fffffff);  // R7 min < max
    apply(2'b10, 6'b101010, 32'h7fffffff, 32'h80000000);  // R7 max > min
    apply(2'b10, 6'b101010, 32'h80000000, 32'h00000001);  // R7 wrap case, R10
    apply(2'b10, 6'b101010, 32'hffffffff, 32'h00000000);  // R7 -1 < 0
    apply(2'b10, 6'b111111, 32'h00000003, 32'h00000004);  // R4 undefined -> add
    apply(2'b11, 6'b000000, 32'h7fffffff, 32'h7fffffff);  // R4 class 11, R9
    apply(2'b11, 6'b100010, 32'h00000005, 32'h00000007);  // R3 class 11 defers

    for (int i = 0; i < 400; i++) begin
      apply(2'($urandom), pick_funct(), pick_operand(), pick_operand());
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule